// File: doc/BRIEF.md
# Scan-Chain Parameter Cache Controller

The block keeps a local copy of a serial configuration scan chain for a reconfigurable clock-generation device. A host edits that copy one named field at a time, choosing a field with a type code and a parameter code. A write request stores bits from `din` into the field. A read request gathers the field onto `dout`. Each request is a one-cycle pulse. It opens a busy window that starts on the next clock edge, and data moves one cache bit per clock during that window.

A reconfigure request pushes the whole cached chain to the device. The chain goes out most significant bit first on `scan_data`, one bit per clock, with `scan_clk_en` high. One `scan_write` strobe follows the last bit. The cache itself is not changed by this. If no field has been written since the previous reconfigure, the serial shift is skipped and only the strobe is issued. This lets the host repeat the same load cheaply, for example for burst phase steps.

Top module: `scanchain_param_cache`

## Requirements
- R1: `rd_req`, `wr_req` and `cfg_req` are sampled on the rising edge only while `busy` is low. An accepted request raises `busy` from the next edge onward. `busy` is never high in the cycle in which the accepted request is presented.
- R2: A read of a mapped field holds `busy` high for field-length + 1 cycles. When `busy` falls, bit i of `dout` equals cache bit offset+i, and the `dout` bits above the field length are 0.
- R3: A write takes `din` at the request edge and stores its low field-length bits. Any change on `din` while `busy` is high has no effect. `busy` lasts field-length + 1 cycles.
- R4: Field map. Type codes 0 to 7 each own an 18-bit slice at offset 18×type. Within a slice, param 0 is 8 bits at +0, param 1 is 8 bits at +8, param 2 is 1 bit at +16 and param 3 is 1 bit at +17. Data bit i corresponds to cache bit offset+i.
- R5: A selection with type ≥ 8 or param ≥ 4 is unmapped. A read of it returns 0, a write of it changes nothing, and `busy` lasts 1 cycle.
- R6: After reset, or after any mapped write since the last reconfigure, a reconfigure drives `scan_clk_en` high for 144 consecutive cycles, starting with the cycle after the request. During those cycles `scan_data` carries cache bits 143 down to 0. One `scan_write` cycle follows, and `busy` lasts 145 cycles.
- R7: A reconfigure leaves every cache bit unchanged.
- R8: A reconfigure with no mapped write since the previous reconfigure keeps `scan_clk_en` low and asserts `scan_write` for 1 cycle, with `busy` high for that single cycle.
- R9: Requests presented while `busy` is high are dropped.
- R10: When several requests arrive in the same idle cycle, reconfigure wins over write, and write wins over read. The losing requests are discarded.
- R11: A request still high in the first idle cycle after `busy` falls is accepted again as a new command.
- R12: Synchronous reset clears `busy`, `dout` and the scan outputs, and loads the cache with `DEF_IMAGE`, which by default is 18'h12C35 repeated in every slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read-field request pulse |
| wr_req | input | 1 | Write-field request pulse |
| cfg_req | input | 1 | Reconfigure request pulse |
| sel_type | input | TYPE_W | Type code of the selected field |
| sel_param | input | PARAM_W | Parameter code of the selected field |
| din | input | DATA_W | Write data, field value in the low bits |
| dout | output | DATA_W | Read data, valid while busy is low |
| busy | output | 1 | Operation in progress |
| scan_data | output | 1 | Serial chain data, MSB first |
| scan_clk_en | output | 1 | Scan clock enable during the shift |
| scan_write | output | 1 | One-cycle scan-write strobe |

## Verification
Every result is due at a cycle fixed by the request edge. `busy` is first seen high one cycle after that edge. It stays high for length + 1 cycles for a read or write, 145 cycles for a full reconfigure and 1 cycle for a strobe-only one. The read data and the captured chain are due in the first cycle with `busy` low again. The driver applies and releases each pulse on falling edges and pushes the item expected for that request. The monitor samples on falling edges, measures each busy window and compares the window length, `dout`, the count of scan-enabled bits, the strobe count and the image gathered by a serial sink with the popped item. A busy window that has no matching item counts as a failure, which is how dropped and discarded requests are caught.

// File: rtl/scpc_pkg.sv
package scpc_pkg;
  localparam int SLOT_W = 18;
  localparam int FIELDS_PER_SLOT = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_SHIFT,
    ST_STROBE
  } scpc_state_e;

  typedef struct packed {
    logic        valid;
    logic [15:0] off;
    logic [3:0]  len;
  } scpc_field_t;

  // position of a field inside its slot
  function automatic int field_base(input int p);
    case (p)
      0:       return 0;
      1:       return 8;
      2:       return 16;
      default: return 17;
    endcase
  endfunction

  function automatic int field_len(input int p);
    return (p < 2) ? 8 : 1;
  endfunction

  function automatic scpc_field_t sel_field(input int ntypes, input int t, input int p);
    scpc_field_t f;
    f = '0;
    if (t < ntypes && p < FIELDS_PER_SLOT) begin
      f.valid = 1'b1;
      f.off   = 16'(t * SLOT_W + field_base(p));
      f.len   = 4'(field_len(p));
    end
    return f;
  endfunction
endpackage

// File: rtl/scpc_cache.sv
module scpc_cache #(
  parameter int CACHE_W = 144,
  parameter int IDX_W = 8,
  parameter logic [CACHE_W-1:0] DEF_IMAGE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic               wbit,
  input  logic [IDX_W-1:0]   ridx,
  output logic               rbit,
  output logic [CACHE_W-1:0] img
);
  always_ff @(posedge clk) begin
    if (rst) img <= DEF_IMAGE;
    else if (we) img[widx] <= wbit;
  end

  assign rbit = img[ridx];
endmodule

// File: rtl/scpc_ctrl.sv
module scpc_ctrl
  import scpc_pkg::*;
#(
  parameter int NUM_TYPES = 8,
  parameter int TYPE_W = 4,
  parameter int PARAM_W = 3,
  parameter int DATA_W = 9,
  parameter int CACHE_W = 144,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic               wr_req,
  input  logic               cfg_req,
  input  logic [TYPE_W-1:0]  sel_type,
  input  logic [PARAM_W-1:0] sel_param,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               busy,
  output logic               scan_data,
  output logic               scan_clk_en,
  output logic               scan_write,
  output logic               cache_we,
  output logic [IDX_W-1:0]   cache_widx,
  output logic               cache_wbit,
  output logic [IDX_W-1:0]   cache_ridx,
  input  logic               cache_rbit,
  output logic               reconf_active
);
  localparam int DI_W = $clog2(DATA_W);

  scpc_state_e       st;
  logic [IDX_W-1:0]  cnt;
  logic [IDX_W-1:0]  cur_off;
  logic [3:0]        cur_len;
  logic [DATA_W-1:0] wdata;
  logic              need_shift;
  scpc_field_t       fs;

  // named events for the checks
  logic idle, acc_rd, acc_wr, acc_rc, any_req, field_done, shift_last;

  assign fs         = sel_field(NUM_TYPES, int'(sel_type), int'(sel_param));
  assign idle       = (st == ST_IDLE);
  assign any_req    = rd_req | wr_req | cfg_req;
  assign acc_rc     = idle & cfg_req;
  assign acc_wr     = idle & ~cfg_req & wr_req;
  assign acc_rd     = idle & ~cfg_req & ~wr_req & rd_req;
  assign field_done = (cnt == IDX_W'(cur_len));
  assign shift_last = (cnt == IDX_W'(CACHE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      cur_off    <= '0;
      cur_len    <= '0;
      wdata      <= '0;
      dout       <= '0;
      need_shift <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (acc_rc) begin
            st         <= need_shift ? ST_SHIFT : ST_STROBE;
            need_shift <= 1'b0;
          end else if (acc_wr) begin
            cur_off <= IDX_W'(fs.off);
            cur_len <= fs.valid ? fs.len : 4'd0;
            wdata   <= din;
            if (fs.valid) need_shift <= 1'b1;
            st <= ST_WR;
          end else if (acc_rd) begin
            cur_off <= IDX_W'(fs.off);
            cur_len <= fs.valid ? fs.len : 4'd0;
            dout    <= '0;
            st      <= ST_RD;
          end
        end
        ST_RD: begin
          if (field_done) st <= ST_IDLE;
          else begin
            dout[cnt[DI_W-1:0]] <= cache_rbit;
            cnt <= cnt + 1'b1;
          end
        end
        ST_WR: begin
          if (field_done) st <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        ST_SHIFT: begin
          if (shift_last) st <= ST_STROBE;
          else cnt <= cnt + 1'b1;
        end
        ST_STROBE: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign busy          = ~idle;
  assign reconf_active = (st == ST_SHIFT) | (st == ST_STROBE);
  assign cache_we      = (st == ST_WR) & ~field_done;
  assign cache_widx    = cur_off + cnt;
  assign cache_wbit    = wdata[cnt[DI_W-1:0]];
  assign cache_ridx    = (st == ST_SHIFT) ? (IDX_W'(CACHE_W - 1) - cnt) : (cur_off + cnt);
  assign scan_clk_en   = (st == ST_SHIFT);
  assign scan_data     = (st == ST_SHIFT) & cache_rbit;
  assign scan_write    = (st == ST_STROBE);

  // R1: an accepted request shows busy on the following cycle
  a_r1_busy_follows: assert property (@(posedge clk) disable iff (rst)
    (idle && any_req) |=> busy);
  // R1: busy only rises after a request was presented
  a_r1_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(any_req));
  // R3: the captured write value holds for the whole write window
  a_r3_wdata_held: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && $past(st == ST_WR)) |-> $stable(wdata));
  // R2: busy drops right after the last field bit
  a_r2_read_ends: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && field_done) |=> !busy);
  // R6: scan enable only inside a busy window, strobe lasts one cycle
  a_r6_en_in_busy: assert property (@(posedge clk) disable iff (rst)
    scan_clk_en |-> busy);
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    scan_write |=> !scan_write);
  // R8: strobe-only reconfigure when nothing was written
  a_r8_quick_cfg: assert property (@(posedge clk) disable iff (rst)
    (acc_rc && !need_shift) |=> (scan_write && !scan_clk_en));
  // R10: reconfigure wins over simultaneous write and read
  a_r10_cfg_wins: assert property (@(posedge clk) disable iff (rst)
    (idle && cfg_req && wr_req) |=> reconf_active);
endmodule

// File: rtl/scanchain_param_cache.sv
module scanchain_param_cache #(
  parameter int NUM_TYPES = 8,
  parameter int TYPE_W = 4,
  parameter int PARAM_W = 3,
  parameter int DATA_W = 9,
  parameter logic [NUM_TYPES*scpc_pkg::SLOT_W-1:0] DEF_IMAGE = {NUM_TYPES{18'h12C35}}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic               wr_req,
  input  logic               cfg_req,
  input  logic [TYPE_W-1:0]  sel_type,
  input  logic [PARAM_W-1:0] sel_param,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               busy,
  output logic               scan_data,
  output logic               scan_clk_en,
  output logic               scan_write
);
  localparam int CACHE_W = NUM_TYPES * scpc_pkg::SLOT_W;
  localparam int IDX_W = $clog2(CACHE_W);

  logic               c_we, c_wbit, c_rbit, reconf_active;
  logic [IDX_W-1:0]   c_widx, c_ridx;
  logic [CACHE_W-1:0] c_img;

  scpc_cache #(.CACHE_W(CACHE_W), .IDX_W(IDX_W), .DEF_IMAGE(DEF_IMAGE)) u_cache (
    .clk(clk), .rst(rst), .we(c_we), .widx(c_widx), .wbit(c_wbit),
    .ridx(c_ridx), .rbit(c_rbit), .img(c_img)
  );

  scpc_ctrl #(
    .NUM_TYPES(NUM_TYPES), .TYPE_W(TYPE_W), .PARAM_W(PARAM_W),
    .DATA_W(DATA_W), .CACHE_W(CACHE_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .cfg_req(cfg_req),
    .sel_type(sel_type), .sel_param(sel_param), .din(din), .dout(dout),
    .busy(busy), .scan_data(scan_data), .scan_clk_en(scan_clk_en),
    .scan_write(scan_write), .cache_we(c_we), .cache_widx(c_widx),
    .cache_wbit(c_wbit), .cache_ridx(c_ridx), .cache_rbit(c_rbit),
    .reconf_active(reconf_active)
  );

  // R7: the cache image holds still through a reconfigure
  a_r7_cache_hold: assert property (@(posedge clk) disable iff (rst)
    (reconf_active && $past(reconf_active)) |-> $stable(c_img));
endmodule

// File: tb/test_scanchain_param_cache.sv
module test_scanchain_param_cache;
  localparam int NT = 8, TW = 4, PW = 3, DW = 9, CW = 144;
  localparam logic [CW-1:0] IMG0 = {NT{18'h12C35}};

  logic clk = 1'b0, rst = 1'b1, rd_req = 1'b0, wr_req = 1'b0, cfg_req = 1'b0;
  logic [TW-1:0] sel_type = '0;
  logic [PW-1:0] sel_param = '0;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dout;
  wire busy, scan_data, scan_clk_en, scan_write;

  always #4 clk = ~clk;

  scanchain_param_cache i_scanchain_param_cache (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .cfg_req(cfg_req),
    .sel_type(sel_type), .sel_param(sel_param), .din(din), .dout(dout),
    .busy(busy), .scan_data(scan_data), .scan_clk_en(scan_clk_en),
    .scan_write(scan_write)
  );

  int checks = 0, fails = 0;

  typedef struct {
    string           tag;
    int              kind;      // 0 read, 1 write, 2 reconfigure
    int              exp_len;
    logic [DW-1:0]   exp_data;
    logic [CW-1:0]   exp_img;
    int              exp_en;
  } exp_t;
  exp_t sbq[$];

  logic [CW-1:0] m_img;
  bit m_dirty;

  task automatic chk(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // field map restated from the requirements
  function automatic int tb_len(int t, int p);
    if (t >= NT || p >= 4) return 0;
    return (p <= 1) ? 8 : 1;
  endfunction
  function automatic int tb_off(int t, int p);
    int b;
    b = (p == 0) ? 0 : (p == 1) ? 8 : (p == 2) ? 16 : 17;
    return t * 18 + b;
  endfunction

  function automatic exp_t mk(int kind, int t, int p, logic [DW-1:0] d, string tag);
    exp_t e;
    int l, o;
    l = tb_len(t, p);
    o = tb_off(t, p);
    e.tag = tag; e.kind = kind; e.exp_data = '0; e.exp_img = '0; e.exp_en = 0;
    e.exp_len = l + 1;
    if (kind == 0) begin
      for (int i = 0; i < l; i++) e.exp_data[i] = m_img[o+i];
    end else if (kind == 1) begin
      for (int i = 0; i < l; i++) m_img[o+i] = d[i];
      if (l > 0) m_dirty = 1'b1;
    end else begin
      if (m_dirty) begin
        e.exp_en = CW; e.exp_len = CW + 1; e.exp_img = m_img;
      end else e.exp_len = 1;
      m_dirty = 1'b0;
    end
    return e;
  endfunction

  // behavioural scan-chain sink
  logic [CW-1:0] sink = '0;
  int en_cnt = 0, sw_cnt = 0;
  always @(posedge clk) begin
    if (scan_clk_en) begin
      sink <= {sink[CW-2:0], scan_data};
      en_cnt <= en_cnt + 1;
    end
    if (scan_write) sw_cnt <= sw_cnt + 1;
  end

  // monitor: measures each busy window and checks it against the queue
  bit pb = 1'b0;
  int blen = 0, en0 = 0, sw0 = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        if (!pb) begin blen = 1; en0 = en_cnt; sw0 = sw_cnt; end
        else blen++;
      end else if (pb) begin
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 unexpected busy window actual=%0d expected=none", blen);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(e.tag, "busy length", CW'(blen), CW'(e.exp_len));
          if (e.kind == 0) chk(e.tag, "dout", CW'(dout), CW'(e.exp_data));
          if (e.kind == 2) begin
            chk(e.tag, "scan enables", CW'(en_cnt - en0), CW'(e.exp_en));
            chk(e.tag, "scan writes", CW'(sw_cnt - sw0), CW'(1));
            if (e.exp_en > 0) chk(e.tag, "shifted image", sink, e.exp_img);
          end
        end
      end
      pb = busy;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // driver: one-cycle request, pushes the expected item
  task automatic op(int kind, int t, int p, logic [DW-1:0] d, string tag, bit scramble);
    sbq.push_back(mk(kind, t, p, d, tag));
    @(negedge clk);
    chk("R1", "busy before request", CW'(busy), CW'(0));
    sel_type = TW'(t); sel_param = PW'(p); din = d;
    rd_req = (kind == 0); wr_req = (kind == 1); cfg_req = (kind == 2);
    @(negedge clk);
    rd_req = 0; wr_req = 0; cfg_req = 0;
    chk("R1", "busy after request", CW'(busy), CW'(1));
    while (busy) begin
      if (scramble) din = ~din ^ 9'h0F3;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_img = IMG0; m_dirty = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "busy", CW'(busy), CW'(0));
    chk("R12", "dout", CW'(dout), CW'(0));
    chk("R12", "scan outputs", CW'({scan_clk_en, scan_write, scan_data}), CW'(0));
    // R12 default image and R2/R4 reads
    op(0, 0, 0, 0, "R12", 0);
    op(0, 7, 3, 0, "R4", 0);
    op(0, 3, 2, 0, "R4", 0);
    op(0, 5, 1, 0, "R2", 0);
    // R3 write with din disturbed while busy
    op(1, 2, 0, 9'h1A5, "R3", 1);
    op(0, 2, 0, 0, "R3", 0);
    op(1, 4, 1, 9'h03C, "R4", 0);
    op(1, 4, 2, 9'h001, "R4", 0);
    op(0, 4, 1, 0, "R4", 0);
    op(0, 4, 2, 0, "R4", 0);
    op(0, 4, 0, 0, "R4", 0);
    // R5 unmapped selections
    op(0, 9, 0, 0, "R5", 0);
    op(1, 1, 5, 9'h1FF, "R5", 0);
    op(1, 15, 7, 9'h1FF, "R5", 0);
    op(0, 1, 0, 0, "R5", 0);
    op(0, 1, 1, 0, "R5", 0);
    // R6 full shift, R7 cache kept, R8 strobe only
    op(2, 0, 0, 0, "R6", 0);
    op(0, 2, 0, 0, "R7", 0);
    op(0, 4, 1, 0, "R7", 0);
    op(2, 0, 0, 0, "R8", 0);
    op(2, 0, 0, 0, "R8", 0);
    // R9 requests during busy are dropped
    sbq.push_back(mk(1, 6, 0, 9'h077, "R9"));
    @(negedge clk);
    sel_type = 6; sel_param = 0; din = 9'h077; wr_req = 1;
    @(negedge clk);
    wr_req = 0;
    @(negedge clk);
    sel_param = 1; din = 9'h011; wr_req = 1; rd_req = 1; cfg_req = 1;
    @(negedge clk);
    wr_req = 0; rd_req = 0; cfg_req = 0;
    wait_idle();
    op(0, 6, 1, 0, "R9", 0);
    op(0, 6, 0, 0, "R9", 0);
    // R10 priority: reconfigure wins, write and read discarded
    sbq.push_back(mk(2, 0, 0, 0, "R10"));
    @(negedge clk);
    sel_type = 0; sel_param = 1; din = 9'h05A;
    cfg_req = 1; wr_req = 1; rd_req = 1;
    @(negedge clk);
    cfg_req = 0; wr_req = 0; rd_req = 0;
    wait_idle();
    op(0, 0, 1, 0, "R10", 0);
    // R10 write wins over read
    sbq.push_back(mk(1, 3, 0, 9'h0C3, "R10"));
    @(negedge clk);
    sel_type = 3; sel_param = 0; din = 9'h0C3; wr_req = 1; rd_req = 1;
    @(negedge clk);
    wr_req = 0; rd_req = 0;
    wait_idle();
    op(0, 3, 0, 0, "R10", 0);
    // R11 held request repeats once busy clears
    sbq.push_back(mk(0, 3, 0, 0, "R11"));
    sbq.push_back(mk(0, 3, 0, 0, "R11"));
    @(negedge clk);
    sel_type = 3; sel_param = 0; rd_req = 1;
    @(negedge clk);
    wait_idle();
    @(negedge clk);
    rd_req = 0;
    wait_idle();
    // R6 reconfigure after write shifts again
    op(1, 7, 1, 9'h0E1, "R6", 0);
    op(2, 0, 0, 0, "R6", 0);
    op(2, 0, 0, 0, "R8", 0);
    repeat (4) @(negedge clk);
    chk("R9", "pending items", CW'(sbq.size()), CW'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule